// File: doc/BRIEF.md
# Vector Pack with Saturation

This block takes two 64-bit source vectors and returns a single 64-bit vector. Each source element is narrowed to half its width, so the two sources together fill exactly one result. A value that does not fit in the narrower element is clamped to the nearest limit rather than cut off. The narrowed elements of the first source, `srcA`, fill the low half of the result in their original lane order. Those of the second source, `srcB`, fill the high half in the same way.

A two-bit mode input picks the conversion. The modes are signed 32-bit to signed 16-bit, signed 16-bit to signed 8-bit, and signed 16-bit to unsigned 8-bit. The fourth code is reserved and yields an all-zero result.

The conversion logic is purely combinational. A parameter decides whether an output register follows it. With the register present (the default), `inValid` loads the register and is echoed on `resValid` one cycle later. With the register absent, the result follows the inputs directly.

Top module: `vec_pack_sat`

## Requirements
- R1: With mode 2'b00, each signed 32-bit lane k of srcA (bits 32k+31:32k) becomes the signed 16-bit result field 16k+15:16k, and srcB lane k becomes field 16(k+2)+15:16(k+2). Values above 32767 give 16'h7FFF and values below -32768 give 16'h8000.
- R2: With mode 2'b01, each signed 16-bit lane k of srcA (bits 16k+15:16k) becomes the signed byte at result bits 8k+7:8k, and srcB lane k becomes the byte at 8(k+4)+7:8(k+4). Values above 127 give 8'h7F and values below -128 give 8'h80.
- R3: With mode 2'b10, the lanes are placed as in R2, but each byte is unsigned. Any negative input gives 8'h00, and any input above 255 gives 8'hFF.
- R4: An input that lies inside the target range is passed through unchanged. In R1 this covers -32768 to 32767, in R2 it covers -128 to 127, and in R3 it covers 0 to 255.
- R5: Mode 2'b11 produces an all-zero result.
- R6: With the output register present, a vector presented with inValid high appears on result after the next rising clock edge, and resValid is high in that same cycle.
- R7: While inValid is low, result keeps its previous value whatever srcA, srcB and mode do, and resValid is low after the next edge.
- R8: While rstN is low, result is zero and resValid is low. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sources and mode are valid and load the output register |
| mode | input | 2 | Conversion select: 00 s32 to s16, 01 s16 to s8, 10 s16 to u8, 11 zero |
| srcA | input | 64 | First source vector; its elements fill the low half of the result |
| srcB | input | 64 | Second source vector; its elements fill the high half of the result |
| resValid | output | 1 | Result register holds a newly loaded vector |
| result | output | 64 | Packed and saturated result |

## Verification
Clamping toward the maximum and clamping toward the minimum can both happen in one cycle, in neighbouring lanes of the same vector. The vectors are built so that each source carries an over-range lane next to an under-range lane and an exact-limit lane. Each vector is judged as a whole against a result worked out by hand, so that a lane swap or a wrong limit in any single lane shows up. Mode changes on consecutive cycles with inValid held high are also covered, which checks that the register captures the new mode's lanes without mixing them with the old ones.

// File: rtl/vps_pkg.sv
package vps_pkg;

  typedef enum logic [1:0] {
    PK_S32_S16 = 2'b00,
    PK_S16_S8  = 2'b01,
    PK_S16_U8  = 2'b10,
    PK_ZERO    = 2'b11
  } packMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wordOut;      // select the 32->16 lane set
    logic unsignedOut;  // byte lanes clamp to the unsigned range
    logic zeroOut;      // force an all-zero result
    logic load;         // capture into the output register
  } packCtl_t;

endpackage

// File: rtl/vps_sat_lane.sv
module vps_sat_lane #(
  parameter int IN_W = 16,
  localparam int OUT_W = IN_W / 2
) (
  input  logic [IN_W-1:0]  wideVal,
  input  logic             unsignedOut,
  output logic [OUT_W-1:0] narrowVal
);

  logic              signBit;
  logic [IN_W-OUT_W:0]   upperS;   // bits that must agree for a signed fit
  logic [IN_W-OUT_W-1:0] upperU;   // bits that must be zero for an unsigned fit

  always_comb begin
    signBit = wideVal[IN_W-1];
    upperS  = wideVal[IN_W-1:OUT_W-1];
    upperU  = wideVal[IN_W-1:OUT_W];
    if (unsignedOut) begin
      if (signBit)       narrowVal = '0;
      else if (|upperU)  narrowVal = '1;
      else               narrowVal = wideVal[OUT_W-1:0];
    end else begin
      if ((&upperS) || !(|upperS)) narrowVal = wideVal[OUT_W-1:0];
      else if (signBit)            narrowVal = {1'b1, {(OUT_W-1){1'b0}}};
      else                         narrowVal = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/vps_control.sv
module vps_control
  import vps_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic [1:0] mode,
  output packCtl_t ctl,
  output logic     resValid
);

  packMode_e curMode;

  always_comb begin
    curMode         = packMode_e'(mode);
    ctl.wordOut     = (curMode == PK_S32_S16);
    ctl.unsignedOut = (curMode == PK_S16_U8);
    ctl.zeroOut     = (curMode == PK_ZERO);
    ctl.load        = inValid;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign resValid = validQ;
    end else begin : g_comb
      assign resValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/vps_datapath.sv
module vps_datapath
  import vps_pkg::*;
#(
  parameter int VEC_W   = 64,
  parameter int WIDE_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  packCtl_t         ctl,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] result
);

  localparam int MID_W      = WIDE_W / 2;
  localparam int WIDE_LANES = 2 * VEC_W / WIDE_W;
  localparam int MID_LANES  = 2 * VEC_W / MID_W;

  logic [2*VEC_W-1:0] both;
  logic [VEC_W-1:0]   packWide;
  logic [VEC_W-1:0]   packMid;
  logic [VEC_W-1:0]   nextRes;

  // srcA below srcB so lane order runs A then B
  assign both = {srcB, srcA};

  generate
    for (genvar i = 0; i < WIDE_LANES; i++) begin : g_wide
      vps_sat_lane #(.IN_W(WIDE_W)) u_lane (
        .wideVal    (both[i*WIDE_W +: WIDE_W]),
        .unsignedOut(1'b0),
        .narrowVal  (packWide[i*MID_W +: MID_W])
      );
    end
    for (genvar j = 0; j < MID_LANES; j++) begin : g_mid
      vps_sat_lane #(.IN_W(MID_W)) u_lane (
        .wideVal    (both[j*MID_W +: MID_W]),
        .unsignedOut(ctl.unsignedOut),
        .narrowVal  (packMid[j*(MID_W/2) +: MID_W/2])
      );
    end
  endgenerate

  always_comb begin
    if (ctl.zeroOut)      nextRes = '0;
    else if (ctl.wordOut) nextRes = packWide;
    else                  nextRes = packMid;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [VEC_W-1:0] resQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         resQ <= '0;
        else if (ctl.load) resQ <= nextRes;
      end
      assign result = resQ;
    end else begin : g_comb
      assign result = nextRes;
    end
  endgenerate

endmodule

// File: rtl/vec_pack_sat.sv
module vec_pack_sat
  import vps_pkg::*;
#(
  parameter int VEC_W   = 64,
  parameter int WIDE_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             resValid,
  output logic [VEC_W-1:0] result
);

  packCtl_t ctl;

  vps_control #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .mode    (mode),
    .ctl     (ctl),
    .resValid(resValid)
  );

  vps_datapath #(.VEC_W(VEC_W), .WIDE_W(WIDE_W), .OUT_REG(OUT_REG)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .srcA  (srcA),
    .srcB  (srcB),
    .result(result)
  );

endmodule

// File: rtl/vec_pack_sat_chk.sv
module vec_pack_sat_chk #(
  parameter int VEC_W   = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       mode,
  input logic [VEC_W-1:0] srcA,
  input logic [VEC_W-1:0] srcB,
  input logic             resValid,
  input logic [VEC_W-1:0] result
);

  generate
    if (OUT_REG) begin : g_chk
      AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |-> (result == '0 && !resValid)); // R8

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> resValid); // R6

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> ($stable(result) && !resValid)); // R7

      AST_ZERO_MODE: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && mode == 2'b11) |=> (result == '0)); // R5

      AST_CLAMP_HIGH_WORD: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && mode == 2'b00 && !srcA[31] && srcA[30:15] != '0) |=> (result[15:0] == 16'h7FFF)); // R1

      AST_CLAMP_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && mode == 2'b01 && srcA[15] && srcA[14:7] != 8'hFF) |=> (result[7:0] == 8'h80)); // R2

      AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && mode == 2'b10 && srcA[15]) |=> (result[7:0] == 8'h00)); // R3

      AST_PASS_WORD: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && mode == 2'b00 && (srcA[31:15] == '0 || srcA[31:15] == '1))
          |=> (result[15:0] == $past(srcA[15:0]))); // R4
    end
  endgenerate

endmodule

bind vec_pack_sat vec_pack_sat_chk #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .mode    (mode),
  .srcA    (srcA),
  .srcB    (srcB),
  .resValid(resValid),
  .result  (result)
);

// File: tb/vec_pack_sat_tb.sv
module vec_pack_sat_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        resValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vec_pack_sat u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .srcA(srcA), .srcB(srcB), .resValid(resValid), .result(result)
  );

  // {mode, srcA, srcB, expected}
  localparam int NVEC = 8;
  localparam logic [193:0] VEC [NVEC] = '{
    {2'b00, 64'h0001_0000_0000_1234, 64'h8000_0000_FFFF_FFFF, 64'h8000_FFFF_7FFF_1234},
    {2'b00, 64'h0000_7FFF_FFFF_8000, 64'hFFFF_7FFF_0000_8000, 64'h8000_7FFF_7FFF_8000},
    {2'b01, 64'h0080_FF7F_007F_FF80, 64'h1234_8000_FFFF_0005, 64'h7F80_FF05_7F80_7F80},
    {2'b10, 64'h0100_00FF_FFFF_0000, 64'h8000_7FFF_0080_0001, 64'h00FF_8001_FFFF_0000},
    {2'b11, 64'h0123_4567_89AB_CDEF, 64'h7FFF_0000_8000_0001, 64'h0000_0000_0000_0000},
    {2'b01, 64'h0011_0022_FFF0_0000, 64'h007F_FF80_0001_FFFE, 64'h7F80_01FE_1122_F000},
    {2'b10, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000, 64'h0000_0000_FFFF_FFFF},
    {2'b00, 64'h0000_0000_0000_0000, 64'h7FFF_FFFF_8000_0001, 64'h7FFF_8000_0000_0000}
  };

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check64("R8 result in reset", result, 64'h0);
    check1("R8 resValid in reset", resValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk, vectors back to back (R6 latency, mode changes every cycle)
    inValid = 1'b1;
    {mode, srcA, srcB} = VEC[0][193:64];
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check64(reqOf(VEC[i][193:192]), result, VEC[i][63:0]);
      check1("R6 resValid", resValid, 1'b1);
      if (i + 1 < NVEC) {mode, srcA, srcB} = VEC[i+1][193:64];
    end

    // R7: idle input holds the result
    inValid = 1'b0;
    mode = 2'b01;
    srcA = 64'h1111_2222_3333_4444;
    srcB = 64'h5555_6666_7777_8888;
    @(negedge clk);
    check64("R7 result held", result, 64'h7FFF_8000_0000_0000);
    check1("R7 resValid low", resValid, 1'b0);
    mode = 2'b11;
    @(negedge clk);
    check64("R7 result held with zero mode", result, 64'h7FFF_8000_0000_0000);

    // R4: in-range values in each mode
    inValid = 1'b1;
    mode = 2'b00; srcA = 64'hFFFF_8001_0000_7FFE; srcB = 64'h0000_0001_FFFF_FFFE;
    @(negedge clk);
    check64("R4 word pass", result, 64'h0001_FFFE_8001_7FFE);
    mode = 2'b10; srcA = 64'h00FF_0000_0080_007F; srcB = 64'h0001_00FE_0002_0003;
    @(negedge clk);
    check64("R4 unsigned pass", result, 64'h01FE_0203_FF00_807F);
    mode = 2'b01; srcA = 64'hFF80_007F_0000_FFFF; srcB = 64'h0040_FFC0_0001_FF81;
    @(negedge clk);
    check64("R4 signed byte pass", result, 64'h40C0_0181_807F_00FF);

    // R8: asynchronous reset mid-run
    inValid = 1'b0;
    #1 rstN = 1'b0;
    #1 check64("R8 async clear", result, 64'h0);
    check1("R8 async valid clear", resValid, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule